// File: doc/BRIEF.md
# Programmable Pad Input/Output Cell

This block is one bidirectional pad cell whose behaviour is chosen by a static 6-bit pin-type word. The word is cut into three 2-bit fields. One field picks how the pad reaches the fabric: registered, direct, registered and then latched, or latched straight from the pad. A second field picks how fabric data reaches the pad: double data rate, direct, registered, or registered and inverted. The third field picks the output enable: never, always, taken straight from an input, or registered. A second input output always captures the pad on the opposite input-clock edge, so double-data-rate capture is available in every mode.

The input side and the output side each have their own clock. One clock enable gates every register in the cell. A static clock-inversion input swaps the rising and falling edges everywhere, including the level that steers the double-data-rate output multiplexer. A latch-hold input freezes the latch-based input modes while it is high. All state clears to 0 on an asynchronous active-low reset.

Top module: `pad_io_cell`

## Requirements
- R1: While reset is low, every register and the input latch read 0. So inData1 is 0, inData0 is 0 in every input mode except direct, and a registered output enable leaves the pad undriven.
- R2: With pinType[1:0]=2'b00, inData0 is the pad value sampled on the active edge of the input clock.
- R3: With pinType[1:0]=2'b01, inData0 follows the pad combinationally.
- R4: With pinType[1:0]=2'b10, the pad is first registered on the active input-clock edge. That register then reaches inData0 through a latch that is transparent while latchHold is low and holds while it is high.
- R5: With pinType[1:0]=2'b11, inData0 is a latch fed straight from the pad, transparent while latchHold is low and holding while it is high.
- R6: inData1 is the pad value sampled on the inactive edge of the input clock, whatever the input mode.
- R7: With pinType[3:2]=2'b00 (double data rate), outData0 is registered on the active output-clock edge and outData1 on the inactive edge. The pad carries the first register while the effective output clock is high and the second while it is low.
- R8: With pinType[3:2]=2'b10 the pad carries outData0 directly. With 2'b01 it carries outData0 registered on the active output-clock edge. With 2'b11 it carries the inverse of outData0, registered the same way.
- R9: The output-enable field pinType[5:4] gives: 2'b00 never driven, 2'b01 always driven, 2'b10 driven while outEnable is high, 2'b11 outEnable registered on the active output-clock edge. Whenever the resulting enable is low, the pad is high impedance.
- R10: While clkEn is low, no register in the cell changes.
- R11: With invClk high, every active edge becomes the falling edge of its raw clock and every inactive edge becomes the rising edge. The double-data-rate multiplexer then selects the first register while the raw output clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset |
| pinType | input | 6 | Static mode word: [1:0] input, [3:2] output data, [5:4] output enable |
| invClk | input | 1 | Static clock-edge inversion |
| inClk | input | 1 | Input-side clock |
| outClk | input | 1 | Output-side clock |
| clkEn | input | 1 | Enable shared by all registers |
| latchHold | input | 1 | Latch freezes while high |
| outData0 | input | 1 | Output data, active-edge slot |
| outData1 | input | 1 | Output data, inactive-edge slot |
| outEnable | input | 1 | Output enable request |
| inData0 | output | 1 | Input data per input mode |
| inData1 | output | 1 | Pad sampled on the inactive input edge |
| pad | inout | 1 | Bidirectional pad |

## Verification
The direct and latch-transparent paths settle in the same time step as their input. The pad is therefore compared a short delay after each input change. Registered results appear one edge after the enabling clock edge, on the active or inactive edge chosen by the mode and invClk. The bench steps through each half period in a fixed order: output edge, model update, latch-hold change, new data, input edge, model update, compare. Every value is thus sampled at least 1 ns away from any edge that could move it.

// File: rtl/pad_io_pkg.sv
`timescale 1ns/100ps
package pad_io_pkg;
  localparam int PIN_TYPE_W = 6;
  localparam int FIELD_W    = 2;
  localparam int IN_LSB     = 0;
  localparam int OUT_LSB    = IN_LSB + FIELD_W;
  localparam int OE_LSB     = OUT_LSB + FIELD_W;

  typedef enum logic [FIELD_W-1:0] {
    IN_REG       = 2'b00,
    IN_DIRECT    = 2'b01,
    IN_REG_LATCH = 2'b10,
    IN_PAD_LATCH = 2'b11
  } inMode_e;

  typedef enum logic [FIELD_W-1:0] {
    OUT_DDR     = 2'b00,
    OUT_REG     = 2'b01,
    OUT_DIRECT  = 2'b10,
    OUT_REG_INV = 2'b11
  } outMode_e;

  typedef enum logic [FIELD_W-1:0] {
    OE_OFF    = 2'b00,
    OE_ON     = 2'b01,
    OE_DIRECT = 2'b10,
    OE_REG    = 2'b11
  } oeMode_e;

  typedef struct packed {
    inMode_e  inMode;
    outMode_e outMode;
    oeMode_e  oeMode;
  } padCtrl_t;
endpackage

// File: rtl/pad_io_ctrl.sv
`timescale 1ns/100ps
module pad_io_ctrl
  import pad_io_pkg::*;
(
  input  logic [PIN_TYPE_W-1:0] pinType,
  input  logic                  invClk,
  input  logic                  inClk,
  input  logic                  outClk,
  output padCtrl_t              ctrl,
  output logic                  inClkEff,
  output logic                  outClkEff
);
  // Field decode of the static mode word
  always_comb begin
    ctrl.inMode  = inMode_e'(pinType[IN_LSB +: FIELD_W]);
    ctrl.outMode = outMode_e'(pinType[OUT_LSB +: FIELD_W]);
    ctrl.oeMode  = oeMode_e'(pinType[OE_LSB +: FIELD_W]);
  end

  // One inversion swaps every edge in the cell, DDR select included
  assign inClkEff  = inClk ^ invClk;
  assign outClkEff = outClk ^ invClk;
endmodule

// File: rtl/pad_io_datapath.sv
`timescale 1ns/100ps
module pad_io_datapath
  import pad_io_pkg::*;
(
  input  logic     rstN,
  input  padCtrl_t ctrl,
  input  logic     inClkEff,
  input  logic     outClkEff,
  input  logic     clkEn,
  input  logic     latchHold,
  input  logic     padIn,
  input  logic     outData0,
  input  logic     outData1,
  input  logic     outEnable,
  output logic     inData0,
  output logic     inData1,
  output logic     padOut,
  output logic     padOe
);
  logic inRegPos, inRegNeg, inLatch, latchSrc;
  logic ddrPos, ddrNeg, outReg, oeReg, outRegNext;

  // ---------------- input side ----------------
  always_ff @(posedge inClkEff or negedge rstN) begin
    if (!rstN)      inRegPos <= 1'b0;
    else if (clkEn) inRegPos <= padIn;
  end

  always_ff @(negedge inClkEff or negedge rstN) begin
    if (!rstN)      inRegNeg <= 1'b0;
    else if (clkEn) inRegNeg <= padIn;
  end

  assign latchSrc = (ctrl.inMode == IN_REG_LATCH) ? inRegPos : padIn;

  always_latch begin
    if (!rstN)           inLatch = 1'b0;
    else if (!latchHold) inLatch = latchSrc;
  end

  always_comb begin
    case (ctrl.inMode)
      IN_REG:       inData0 = inRegPos;
      IN_DIRECT:    inData0 = padIn;
      IN_REG_LATCH: inData0 = inLatch;
      IN_PAD_LATCH: inData0 = inLatch;
    endcase
  end

  assign inData1 = inRegNeg;

  // ---------------- output side ----------------
  assign outRegNext = (ctrl.outMode == OUT_REG_INV) ? ~outData0 : outData0;

  always_ff @(posedge outClkEff or negedge rstN) begin
    if (!rstN) begin
      ddrPos <= 1'b0;
      outReg <= 1'b0;
      oeReg  <= 1'b0;
    end else if (clkEn) begin
      ddrPos <= outData0;
      outReg <= outRegNext;
      oeReg  <= outEnable;
    end
  end

  always_ff @(negedge outClkEff or negedge rstN) begin
    if (!rstN)      ddrNeg <= 1'b0;
    else if (clkEn) ddrNeg <= outData1;
  end

  always_comb begin
    case (ctrl.outMode)
      OUT_DDR:     padOut = outClkEff ? ddrPos : ddrNeg;
      OUT_REG:     padOut = outReg;
      OUT_DIRECT:  padOut = outData0;
      OUT_REG_INV: padOut = outReg;
    endcase
  end

  always_comb begin
    case (ctrl.oeMode)
      OE_OFF:    padOe = 1'b0;
      OE_ON:     padOe = 1'b1;
      OE_DIRECT: padOe = outEnable;
      OE_REG:    padOe = oeReg;
    endcase
  end
endmodule

// File: rtl/pad_io_cell.sv
`timescale 1ns/100ps
module pad_io_cell
  import pad_io_pkg::*;
(
  input  logic                  rstN,
  input  logic [PIN_TYPE_W-1:0] pinType,
  input  logic                  invClk,
  input  logic                  inClk,
  input  logic                  outClk,
  input  logic                  clkEn,
  input  logic                  latchHold,
  input  logic                  outData0,
  input  logic                  outData1,
  input  logic                  outEnable,
  output logic                  inData0,
  output logic                  inData1,
  inout  wire                   pad
);
  padCtrl_t ctrl;
  logic inClkEff, outClkEff, padOut, padOe;

  pad_io_ctrl u_ctrl (
    .pinType  (pinType),
    .invClk   (invClk),
    .inClk    (inClk),
    .outClk   (outClk),
    .ctrl     (ctrl),
    .inClkEff (inClkEff),
    .outClkEff(outClkEff)
  );

  pad_io_datapath u_dp (
    .rstN     (rstN),
    .ctrl     (ctrl),
    .inClkEff (inClkEff),
    .outClkEff(outClkEff),
    .clkEn    (clkEn),
    .latchHold(latchHold),
    .padIn    (pad),
    .outData0 (outData0),
    .outData1 (outData1),
    .outEnable(outEnable),
    .inData0  (inData0),
    .inData1  (inData1),
    .padOut   (padOut),
    .padOe    (padOe)
  );

  assign pad = padOe ? padOut : 1'bz;
endmodule

// File: rtl/pad_io_cell_chk.sv
`timescale 1ns/100ps
module pad_io_cell_chk (
  input logic       rstN,
  input logic [5:0] pinType,
  input logic       invClk,
  input logic       outClk,
  input logic       clkEn,
  input logic       outData0,
  input logic       padOut,
  input logic       padOe
);
  // R9
  oe_off_chk: assert property (@(posedge outClk) disable iff (!rstN)
    (pinType[5:4] == 2'b00) |-> !padOe);

  // R9
  oe_on_chk: assert property (@(posedge outClk) disable iff (!rstN)
    (pinType[5:4] == 2'b01) |-> padOe);

  // R8
  out_direct_chk: assert property (@(posedge outClk) disable iff (!rstN)
    (pinType[3:2] == 2'b10) |-> (padOut == outData0));

  // R8
  out_inv_chk: assert property (@(posedge outClk) disable iff (!rstN)
    (!invClk && pinType[3:2] == 2'b11 && clkEn) |=> (padOut == !$past(outData0)));

  // R10
  en_hold_chk: assert property (@(posedge outClk) disable iff (!rstN)
    (!invClk && pinType[3:2] == 2'b01 && !clkEn) |=> $stable(padOut));
endmodule

bind pad_io_cell pad_io_cell_chk u_chk (
  .rstN    (rstN),
  .pinType (pinType),
  .invClk  (invClk),
  .outClk  (outClk),
  .clkEn   (clkEn),
  .outData0(outData0),
  .padOut  (padOut),
  .padOe   (padOe)
);

// File: tb/pad_io_cell_tb.sv
`timescale 1ns/100ps
module pad_io_cell_tb;
  logic clk = 1'b0;
  logic inClk = 1'b0;
  logic rstN = 1'b1;
  logic [5:0] pinType = 6'd0;
  logic invClk = 1'b0, clkEn = 1'b1, latchHold = 1'b0;
  logic outData0 = 1'b0, outData1 = 1'b0, outEnable = 1'b0;
  logic drvEn = 1'b1, drvVal = 1'b0;
  logic inData0, inData1;
  wire  pad;

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic sawLowEn = 1'b0;

  // reference state
  logic mInP = 0, mInN = 0, mLat = 0, mDdrP = 0, mDdrN = 0, mOutR = 0, mOeR = 0;

  assign pad = drvEn ? drvVal : 1'bz;

  always #5 clk = ~clk;
  initial begin
    #7.5;
    forever begin inClk = ~inClk; #5; end
  end

  pad_io_cell u_dut (
    .rstN(rstN), .pinType(pinType), .invClk(invClk), .inClk(inClk), .outClk(clk),
    .clkEn(clkEn), .latchHold(latchHold), .outData0(outData0), .outData1(outData1),
    .outEnable(outEnable), .inData0(inData0), .inData1(inData1), .pad(pad)
  );

  task automatic rnd(output logic b);
    b = lfsr[0];
    lfsr = lfsr[0] ? ((lfsr >> 1) ^ 16'hB400) : (lfsr >> 1);
  endtask

  function automatic logic modelOe();
    case (pinType[5:4])
      2'b00: return 1'b0;
      2'b01: return 1'b1;
      2'b10: return outEnable;
      default: return mOeR;
    endcase
  endfunction

  function automatic logic modelOut();
    case (pinType[3:2])
      2'b00: return (clk ^ invClk) ? mDdrP : mDdrN;
      2'b10: return outData0;
      default: return mOutR;
    endcase
  endfunction

  function automatic logic modelPad();
    return modelOe() ? modelOut() : drvVal;
  endfunction

  task automatic latUpdate();
    if (!rstN) mLat = 1'b0;
    else if (!latchHold) mLat = (pinType[1:0] == 2'b10) ? mInP : modelPad();
  endtask

  task automatic check(input string base, input logic act, input logic exp);
    string tag;
    tag = $sformatf("%s%s%s", base, invClk ? " R11" : "", sawLowEn ? " R10" : "");
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b pinType=%b inv=%b t=%0t",
               tag, act, exp, pinType, invClk, $time);
    end
  endtask

  task automatic step(input logic release_now);
    logic a, b, c, d, e, f;
    @(clk);
    #1;  // output edge has passed
    if (rstN && clkEn) begin
      if (clk ^ invClk) begin
        mDdrP = outData0;
        mOutR = (pinType[3:2] == 2'b11) ? ~outData0 : outData0;
        mOeR  = outEnable;
      end else begin
        mDdrN = outData1;
      end
    end
    drvEn = !modelOe();
    latUpdate();
    #0.5;
    rnd(a);
    latchHold = a;
    latUpdate();
    #0.5;  // new data, away from both clocks
    if (release_now) rstN = 1'b1;
    rnd(a); rnd(b); rnd(c); rnd(d); rnd(e); rnd(f);
    outData0 = a; outData1 = b; outEnable = c; drvVal = d;
    clkEn = e | f;
    if (rstN && !clkEn) sawLowEn = 1'b1;
    drvEn = !modelOe();
    latUpdate();
    #1;  // input edge has passed
    if (rstN && clkEn) begin
      if (inClk ^ invClk) mInP = modelPad();
      else mInN = modelPad();
    end
    latUpdate();
    #1;  // compare
    case (pinType[1:0])
      2'b00: check("R2", inData0, mInP);
      2'b01: check("R3", inData0, modelPad());
      2'b10: check("R4", inData0, mLat);
      default: check("R5", inData0, mLat);
    endcase
    check("R6", inData1, mInN);
    if (modelOe()) check((pinType[3:2] == 2'b00) ? "R7" : "R8", pad, modelOut());
    else check("R9", pad, drvVal);
  endtask

  task automatic runMode(input logic inv, input logic [5:0] mode);
    @(clk);
    #2;
    rstN = 1'b0;
    pinType = mode;
    invClk = inv;
    sawLowEn = 1'b0;
    clkEn = 1'b1;
    mInP = 0; mInN = 0; mLat = 0; mDdrP = 0; mDdrN = 0; mOutR = 0; mOeR = 0;
    drvEn = !modelOe();
    #1;
    // R1: reset state
    check("R1", inData1, 1'b0);
    if (mode[1:0] != 2'b01) check("R1", inData0, 1'b0);
    if (mode[5:4] == 2'b11) check("R1", pad, drvVal);
    if (mode[5:4] == 2'b01 && mode[2]) check("R1", pad, 1'b0);
    step(1'b0);
    step(1'b0);
    step(1'b1);
    for (int k = 0; k < 24; k++) step(1'b0);
  endtask

  initial begin
    for (int inv = 0; inv < 2; inv++)
      for (int m = 0; m < 64; m++)
        runMode(inv[0], m[5:0]);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule